// File: doc/BRIEF.md
# Oscillator Discipline Loop Controller

This block steers a crystal oscillator toward a reference by acting on periodic frequency measurements. Each strobe delivers a raw count whose nominal value is 0x6800. The block turns each count into a signed offset and adds it to a running total over an averaging cycle of programmable length. In summing mode the offset itself is added. In voting mode only its sign is added. When a cycle closes, the block either leaves the 14-bit tuning code alone, moves it one fine step, or moves it one coarse step of 16 codes. The direction depends on the sign of the total and on a slope setting.

Around this arithmetic sits a four-state supervisor: Locked, Holdover, Unlocked and Disabled. A single wild sample drops a locked loop into Holdover. In Holdover the tuning code is frozen and a counter runs toward a timeout that ends in Unlocked. A good averaged cycle brings an unlocked loop back to Locked.

Software pulses can disable the loop, re-enable it, load a coarse tuning value while the loop is disabled, and clear a four-bit sticky alarm register. A reference-output enable lets downstream drivers mute the reference while the loop cannot vouch for it.

Top module: `fll_steer`

## Requirements
- R1: After reset the state is Unlocked (loop_state encoding: 0 Locked, 1 Holdover, 2 Unlocked, 3 Disabled), tune_code is 0x2000 and alarm_flags is 0.
- R2: In summing mode each accepted sample adds (samp_val - 0x6800) to the total. A cycle closes on the accepted sample that brings the count to cfg_cycle_len; a length of 0 acts as 1. No step is taken before the cycle closes.
- R3: In voting mode each accepted sample adds +1 when samp_val is above 0x6800, -1 when below, and 0 when equal.
- R4: At cycle close, when the magnitude of the total is below cfg_dead_band, tune_code does not change.
- R5: At cycle close with magnitude at least cfg_dead_band, the code moves by 16 if the magnitude is at least cfg_coarse_thr and by 1 otherwise. A positive total moves the code down when cfg_slope_neg is 0 and up when it is 1; a negative total moves it the other way.
- R6: Steps saturate at 0x0000 and 0x3FFF. A downward step that ends on 0x0000 sets alarm bit 1, and an upward step that ends on 0x3FFF sets alarm bit 2.
- R7: In Locked, a sample whose offset magnitude is at least cfg_hold_thr moves the loop to Holdover and discards the partial total.
- R8: In Holdover, tune_code is frozen. A sample with offset magnitude below cfg_lock_thr returns the loop to Locked.
- R9: The holdover counter starts at 0 on entry to Holdover and counts each further sample that does not relock. When it reaches cfg_hold_wait the loop moves to Unlocked and sets alarm bits 0 and 3.
- R10: In Unlocked, every sample is accepted. A cycle that closes with total magnitude below cfg_lock_thr moves the loop to Locked.
- R11: cmd_disable moves any state to Disabled, where samples are ignored. cmd_tune in Disabled loads tune_code with {tune_coarse, 4'b0000}, and is ignored in every other state. cmd_enable moves Disabled to Unlocked.
- R12: alarm_flags bit 0 sets on every entry to Unlocked from another state. No alarm bit falls except on cmd_alarm_clr, which clears all bits; an event in the same cycle wins over the clear.
- R13: With cfg_out_ctl high, ref_out_en is high only in Locked and Holdover. With cfg_out_ctl low, ref_out_en is always high.
- R14: After any cycle close that applies a step, the next sample is discarded without effect before a new cycle begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_vld | input | 1 | One-cycle strobe marking a new measurement |
| samp_val | input | 16 | Raw measured count, nominal 0x6800 |
| cfg_vote | input | 1 | 1 selects sign voting, 0 selects summing |
| cfg_slope_neg | input | 1 | 1 when a higher code lowers frequency |
| cfg_out_ctl | input | 1 | Enables muting of the reference output |
| cfg_cycle_len | input | 16 | Samples per averaging cycle |
| cfg_dead_band | input | 34 | Minimum total magnitude that causes a step |
| cfg_coarse_thr | input | 34 | Total magnitude selecting the coarse step |
| cfg_lock_thr | input | 34 | Lock threshold for samples and totals |
| cfg_hold_thr | input | 34 | Sample magnitude that leaves Locked |
| cfg_hold_wait | input | 16 | Holdover sample count before unlocking |
| cmd_enable | input | 1 | Pulse: leave Disabled |
| cmd_disable | input | 1 | Pulse: enter Disabled |
| cmd_tune | input | 1 | Pulse: load the coarse tuning value |
| tune_coarse | input | 10 | Coarse tuning value for manual load |
| cmd_alarm_clr | input | 1 | Pulse: clear the alarm register |
| tune_code | output | 14 | Oscillator tuning code |
| loop_state | output | 2 | Current loop state |
| alarm_flags | output | 4 | Sticky alarms: unlock, bottom rail, top rail, timeout |
| ref_out_en | output | 1 | Reference output enable |

## Verification
The embedded properties assume that the configuration inputs stay still while a sample is being processed. They also assume cfg_hold_wait is at least 1, because the bound on the holdover counter is only meaningful against a fixed, nonzero limit. The properties further rely on command pulses and the sample strobe each lasting a single cycle.

The directed stimulus respects these assumptions. It changes configuration only on falling edges between strobes, raises at most one pulse per cycle, and keeps the holdover wait at 3.

// File: rtl/fll_pkg.sv
package fll_pkg;
  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_HOLD = 2'd1,
    ST_UNLK = 2'd2,
    ST_DIS  = 2'd3
  } loop_st_t;

  localparam int AL_N    = 4;
  localparam int AL_UNLK = 0;
  localparam int AL_LO   = 1;
  localparam int AL_HI   = 2;
  localparam int AL_TMO  = 3;
endpackage

// File: rtl/fll_avg.sv
module fll_avg #(
  parameter int SAMP_W = 16,
  parameter int CNT_W  = 16,
  parameter int ACC_W  = 34,
  parameter int CENTRE = 'h6800,
  localparam int OFF_W = SAMP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    acc_en,
  input  logic                    vote,
  input  logic [SAMP_W-1:0]       samp_val,
  input  logic [CNT_W-1:0]        cycle_len,
  output logic                    last,
  output logic signed [OFF_W-1:0] samp_off,
  output logic signed [ACC_W-1:0] sum_nxt
);
  localparam logic [SAMP_W-1:0] CEN = SAMP_W'(CENTRE);

  logic signed [ACC_W-1:0] acc_q, acc_d, contrib;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [CNT_W:0]          cnt_inc;

  assign samp_off = $signed({1'b0, samp_val}) - $signed({1'b0, CEN});

  always_comb begin
    if (vote) begin
      if (samp_off > 0)      contrib = ACC_W'(1);
      else if (samp_off < 0) contrib = '1;
      else                   contrib = '0;
    end else begin
      contrib = {{(ACC_W-OFF_W){samp_off[OFF_W-1]}}, samp_off};
    end
  end

  assign sum_nxt = acc_q + contrib;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign last    = (cnt_inc >= {1'b0, cycle_len});

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (acc_en) begin
      if (last) begin
        acc_d = '0;
        cnt_d = '0;
      end else begin
        acc_d = sum_nxt;
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr || acc_en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R2: the sample count never passes a nonzero cycle length
  assert_cnt_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_len != '0) |-> (cnt_q < cycle_len));
endmodule

// File: rtl/fll_tune.sv
module fll_tune #(
  parameter int CODE_W    = 14,
  parameter int FINE_BITS = 4,
  parameter int RST_CODE  = 'h2000,
  localparam int LOAD_W   = CODE_W - FINE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              step_dn,
  input  logic              step_coarse,
  input  logic              load_en,
  input  logic [LOAD_W-1:0] load_val,
  output logic [CODE_W-1:0] code,
  output logic              at_lo,
  output logic              at_hi
);
  localparam int unsigned     STEP  = 1 << FINE_BITS;
  localparam logic [CODE_W:0] MAX_X = {1'b0, {CODE_W{1'b1}}};

  logic [CODE_W-1:0] code_q, code_d, code_nxt;
  logic [CODE_W:0]   amt, up_sum, dn_dif;

  always_comb begin
    amt    = step_coarse ? (CODE_W+1)'(STEP) : (CODE_W+1)'(1);
    up_sum = {1'b0, code_q} + amt;
    dn_dif = {1'b0, code_q} - amt;
    if (step_dn)
      code_nxt = ({1'b0, code_q} < amt) ? '0 : dn_dif[CODE_W-1:0];
    else
      code_nxt = (up_sum > MAX_X) ? '1 : up_sum[CODE_W-1:0];
  end

  assign at_lo = step_en &&  step_dn && (code_nxt == '0);
  assign at_hi = step_en && !step_dn && (code_nxt == '1);

  always_comb begin
    code_d = code_q;
    if (load_en)      code_d = {load_val, {FINE_BITS{1'b0}}};
    else if (step_en) code_d = code_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 code_q <= CODE_W'(RST_CODE);
    else if (load_en || step_en) code_q <= code_d;
  end

  assign code = code_q;

  // R5: a downward step never raises the code
  assert_dn_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_dn && !load_en) |=> (code_q <= $past(code_q)));
  // R6: an upward step never lowers the code
  assert_up_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_dn && !load_en) |=> (code_q >= $past(code_q)));
  // R5: a step moves the code by at most one coarse step
  assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=>
      (((code_q >= $past(code_q)) ? (code_q - $past(code_q))
                                  : ($past(code_q) - code_q)) <= CODE_W'(STEP)));
endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl
  import fll_pkg::*;
#(
  parameter int OFF_W = 17,
  parameter int CNT_W = 16,
  parameter int ACC_W = 34
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    samp_vld,
  input  logic signed [OFF_W-1:0] samp_off,
  input  logic                    last,
  input  logic signed [ACC_W-1:0] sum_nxt,
  input  logic                    cfg_slope_neg,
  input  logic [ACC_W-1:0]        cfg_dead_band,
  input  logic [ACC_W-1:0]        cfg_coarse_thr,
  input  logic [ACC_W-1:0]        cfg_lock_thr,
  input  logic [ACC_W-1:0]        cfg_hold_thr,
  input  logic [CNT_W-1:0]        cfg_hold_wait,
  input  logic                    cmd_enable,
  input  logic                    cmd_disable,
  input  logic                    cmd_tune,
  input  logic                    cmd_alarm_clr,
  input  logic                    at_lo,
  input  logic                    at_hi,
  output logic                    acc_en,
  output logic                    avg_clr,
  output logic                    step_en,
  output logic                    step_dn,
  output logic                    step_coarse,
  output logic                    load_en,
  output loop_st_t                state,
  output logic [AL_N-1:0]         alarms
);
  loop_st_t        st_q, st_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic [CNT_W:0]   hold_inc;
  logic             settle_q, settle_d;
  logic [AL_N-1:0]  al_q, al_d, ev_set;
  logic [OFF_W-1:0] abs_off_n;
  logic [ACC_W-1:0] abs_off, abs_sum;

  assign abs_off_n = samp_off[OFF_W-1] ? OFF_W'(-samp_off) : OFF_W'(samp_off);
  assign abs_off   = {{(ACC_W-OFF_W){1'b0}}, abs_off_n};
  assign abs_sum   = sum_nxt[ACC_W-1] ? ACC_W'(-sum_nxt) : ACC_W'(sum_nxt);
  assign hold_inc  = {1'b0, hold_q} + 1'b1;

  assign step_coarse = (abs_sum >= cfg_coarse_thr);
  assign step_dn     = sum_nxt[ACC_W-1] ? cfg_slope_neg : !cfg_slope_neg;

  // next-state logic
  always_comb begin
    st_d      = st_q;
    hold_d    = hold_q;
    settle_d  = settle_q;
    acc_en    = 1'b0;
    avg_clr   = 1'b0;
    step_en   = 1'b0;
    load_en   = 1'b0;
    ev_set    = '0;
    if (cmd_disable) begin
      st_d     = ST_DIS;
      avg_clr  = 1'b1;
      settle_d = 1'b0;
    end else if (st_q == ST_DIS) begin
      if (cmd_enable) begin
        st_d            = ST_UNLK;
        ev_set[AL_UNLK] = 1'b1;
      end else if (cmd_tune) begin
        load_en = 1'b1;
      end
    end else if (samp_vld) begin
      if (settle_q) begin
        settle_d = 1'b0;
      end else begin
        unique case (st_q)
          ST_LOCK: begin
            if (abs_off >= cfg_hold_thr) begin
              st_d    = ST_HOLD;
              hold_d  = '0;
              avg_clr = 1'b1;
            end else begin
              acc_en = 1'b1;
              if (last && (abs_sum >= cfg_dead_band)) begin
                step_en  = 1'b1;
                settle_d = 1'b1;
              end
            end
          end
          ST_HOLD: begin
            if (abs_off < cfg_lock_thr) begin
              st_d = ST_LOCK;
            end else if (hold_inc >= {1'b0, cfg_hold_wait}) begin
              st_d            = ST_UNLK;
              ev_set[AL_UNLK] = 1'b1;
              ev_set[AL_TMO]  = 1'b1;
            end else begin
              hold_d = hold_inc[CNT_W-1:0];
            end
          end
          ST_UNLK: begin
            acc_en = 1'b1;
            if (last) begin
              if (abs_sum >= cfg_dead_band) begin
                step_en  = 1'b1;
                settle_d = 1'b1;
              end
              if (abs_sum < cfg_lock_thr) st_d = ST_LOCK;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    al_d = cmd_alarm_clr ? '0 : al_q;
    al_d = al_d | ev_set;
    if (at_lo) al_d[AL_LO] = 1'b1;
    if (at_hi) al_d[AL_HI] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_UNLK;
      hold_q   <= '0;
      settle_q <= 1'b0;
      al_q     <= '0;
    end else begin
      st_q     <= st_d;
      hold_q   <= hold_d;
      settle_q <= settle_d;
      al_q     <= al_d;
    end
  end

  assign state  = st_q;
  assign alarms = al_q;

  // R9: in Holdover the counter stays below a nonzero wait limit
  assert_hold_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_HOLD) && (cfg_hold_wait != '0)) |-> (hold_q < cfg_hold_wait));
  // R12: without a clear no alarm bit falls
  assert_alarm_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_alarm_clr |=> ((al_q & $past(al_q)) == $past(al_q)));
  // R11: Disabled is left only through an enable command
  assert_dis_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DIS) && !cmd_enable) |=> (st_q == ST_DIS));
endmodule

// File: rtl/fll_steer.sv
module fll_steer
  import fll_pkg::*;
#(
  parameter int SAMP_W    = 16,
  parameter int CNT_W     = 16,
  parameter int ACC_W     = 34,
  parameter int CODE_W    = 14,
  parameter int FINE_BITS = 4,
  parameter int CENTRE    = 'h6800,
  parameter int RST_CODE  = 'h2000,
  localparam int OFF_W    = SAMP_W + 1,
  localparam int LOAD_W   = CODE_W - FINE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_vld,
  input  logic [SAMP_W-1:0] samp_val,
  input  logic              cfg_vote,
  input  logic              cfg_slope_neg,
  input  logic              cfg_out_ctl,
  input  logic [CNT_W-1:0]  cfg_cycle_len,
  input  logic [ACC_W-1:0]  cfg_dead_band,
  input  logic [ACC_W-1:0]  cfg_coarse_thr,
  input  logic [ACC_W-1:0]  cfg_lock_thr,
  input  logic [ACC_W-1:0]  cfg_hold_thr,
  input  logic [CNT_W-1:0]  cfg_hold_wait,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              cmd_tune,
  input  logic [LOAD_W-1:0] tune_coarse,
  input  logic              cmd_alarm_clr,
  output logic [CODE_W-1:0] tune_code,
  output logic [1:0]        loop_state,
  output logic [AL_N-1:0]   alarm_flags,
  output logic              ref_out_en
);
  logic [1:0]              rsync_q;
  logic                    rst_n_s;
  logic                    last, acc_en, avg_clr, step_en, step_dn, step_coarse, load_en;
  logic                    at_lo, at_hi;
  logic signed [OFF_W-1:0] samp_off;
  logic signed [ACC_W-1:0] sum_nxt;
  loop_st_t                state;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  fll_avg #(.SAMP_W(SAMP_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .CENTRE(CENTRE)) u_avg (
    .clk(clk), .rst_n(rst_n_s), .clr(avg_clr), .acc_en(acc_en), .vote(cfg_vote),
    .samp_val(samp_val), .cycle_len(cfg_cycle_len), .last(last),
    .samp_off(samp_off), .sum_nxt(sum_nxt));

  fll_ctrl #(.OFF_W(OFF_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .samp_vld(samp_vld), .samp_off(samp_off),
    .last(last), .sum_nxt(sum_nxt), .cfg_slope_neg(cfg_slope_neg),
    .cfg_dead_band(cfg_dead_band), .cfg_coarse_thr(cfg_coarse_thr),
    .cfg_lock_thr(cfg_lock_thr), .cfg_hold_thr(cfg_hold_thr),
    .cfg_hold_wait(cfg_hold_wait), .cmd_enable(cmd_enable),
    .cmd_disable(cmd_disable), .cmd_tune(cmd_tune), .cmd_alarm_clr(cmd_alarm_clr),
    .at_lo(at_lo), .at_hi(at_hi), .acc_en(acc_en), .avg_clr(avg_clr),
    .step_en(step_en), .step_dn(step_dn), .step_coarse(step_coarse),
    .load_en(load_en), .state(state), .alarms(alarm_flags));

  fll_tune #(.CODE_W(CODE_W), .FINE_BITS(FINE_BITS), .RST_CODE(RST_CODE)) u_tune (
    .clk(clk), .rst_n(rst_n_s), .step_en(step_en), .step_dn(step_dn),
    .step_coarse(step_coarse), .load_en(load_en), .load_val(tune_coarse),
    .code(tune_code), .at_lo(at_lo), .at_hi(at_hi));

  assign loop_state = state;
  assign ref_out_en = !cfg_out_ctl || (state == ST_LOCK) || (state == ST_HOLD);

  // R8: the tuning code is frozen across a Holdover cycle
  assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (loop_state == 2'(ST_HOLD)) |=> $stable(tune_code));
  // R12: arriving in Unlocked leaves the unlock alarm set
  assert_unlk_alarm_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(loop_state == 2'(ST_UNLK)) |-> alarm_flags[AL_UNLK]);
  // R11: while disabled the code changes only by a manual load
  assert_dis_code_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((loop_state == 2'(ST_DIS)) && !cmd_tune) |=> $stable(tune_code));
endmodule

// File: tb/sim_fll_steer.sv
module sim_fll_steer;
  localparam int ACC_W = 34;
  localparam int CEN   = 'h6800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_vld = 1'b0;
  logic [15:0] samp_val = 16'(CEN);
  logic        cfg_vote = 1'b0, cfg_slope_neg = 1'b0, cfg_out_ctl = 1'b1;
  logic [15:0] cfg_cycle_len = 16'd4;
  logic [ACC_W-1:0] cfg_dead_band = ACC_W'(3), cfg_coarse_thr = ACC_W'(100);
  logic [ACC_W-1:0] cfg_lock_thr = ACC_W'(10), cfg_hold_thr = ACC_W'(50);
  logic [15:0] cfg_hold_wait = 16'd3;
  logic        cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_tune = 1'b0, cmd_alarm_clr = 1'b0;
  logic [9:0]  tune_coarse = '0;
  logic [13:0] tune_code;
  logic [1:0]  loop_state;
  logic [3:0]  alarm_flags;
  logic        ref_out_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fll_steer u0 (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_val(samp_val),
    .cfg_vote(cfg_vote), .cfg_slope_neg(cfg_slope_neg), .cfg_out_ctl(cfg_out_ctl),
    .cfg_cycle_len(cfg_cycle_len), .cfg_dead_band(cfg_dead_band),
    .cfg_coarse_thr(cfg_coarse_thr), .cfg_lock_thr(cfg_lock_thr),
    .cfg_hold_thr(cfg_hold_thr), .cfg_hold_wait(cfg_hold_wait),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_tune(cmd_tune),
    .tune_coarse(tune_coarse), .cmd_alarm_clr(cmd_alarm_clr),
    .tune_code(tune_code), .loop_state(loop_state), .alarm_flags(alarm_flags),
    .ref_out_en(ref_out_en));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input int off);
    @(negedge clk);
    samp_val = 16'(CEN + off);
    samp_vld = 1'b1;
    @(negedge clk);
    samp_vld = 1'b0;
  endtask

  task automatic send_n(input int off, input int n);
    for (int i = 0; i < n; i++) send(off);
  endtask

  task automatic cmd(input int which);
    @(negedge clk);
    case (which)
      0: cmd_disable = 1'b1;
      1: cmd_enable = 1'b1;
      2: cmd_tune = 1'b1;
      default: cmd_alarm_clr = 1'b1;
    endcase
    @(negedge clk);
    cmd_disable = 1'b0; cmd_enable = 1'b0; cmd_tune = 1'b0; cmd_alarm_clr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 state", loop_state, 2);
    check("R1 code", tune_code, 'h2000);
    check("R1 alarms", alarm_flags, 0);
    check("R13 muted in Unlocked", ref_out_en, 0);
  endtask

  task automatic t_sum_and_settle;
    send_n(20, 3);
    check("R2 no step before cycle close", tune_code, 'h2000);
    send(20);
    check("R5 fine step down", tune_code, 'h1FFF);
    check("R10 stays Unlocked on large total", loop_state, 2);
    send(1000);
    send_n(0, 3);
    check("R14 settle sample discarded", tune_code, 'h1FFF);
    check("R14 cycle not closed early", loop_state, 2);
    send(0);
    check("R4 dead band holds code", tune_code, 'h1FFF);
    check("R10 lock on small total", loop_state, 0);
    check("R13 enabled in Locked", ref_out_en, 1);
  endtask

  task automatic t_coarse_slope;
    cfg_slope_neg = 1'b1;
    send_n(40, 4);
    check("R5 coarse step up with negative slope", tune_code, 'h200F);
    check("R7 small samples stay Locked", loop_state, 0);
    send(0);
    cfg_slope_neg = 1'b0;
  endtask

  task automatic t_vote;
    cfg_vote = 1'b1;
    send_n(-40, 4);
    check("R3 vote gives fine step up", tune_code, 'h2010);
    send(0);
    cfg_vote = 1'b0;
  endtask

  task automatic t_holdover;
    send(60);
    check("R7 enter Holdover", loop_state, 1);
    send_n(20, 2);
    check("R9 still Holdover below wait", loop_state, 1);
    send(5);
    check("R8 relock on small sample", loop_state, 0);
    send(60);
    send_n(20, 3);
    check("R9 timeout to Unlocked", loop_state, 2);
    check("R9 alarms unlock and timeout", alarm_flags, 'b1001);
    check("R8 code frozen through Holdover", tune_code, 'h2010);
    check("R13 muted after timeout", ref_out_en, 0);
  endtask

  task automatic t_alarm_clear;
    repeat (3) @(negedge clk);
    check("R12 alarms sticky", alarm_flags, 'b1001);
    cmd(3);
    check("R12 alarm clear", alarm_flags, 0);
  endtask

  task automatic t_disable;
    cmd(0);
    check("R11 disabled", loop_state, 3);
    tune_coarse = 10'h3FF;
    cmd(2);
    check("R11 manual load", tune_code, 'h3FF0);
    send_n(1000, 4);
    check("R11 samples ignored when disabled", tune_code, 'h3FF0);
    check("R13 muted when disabled", ref_out_en, 0);
    cmd(1);
    check("R11 enable to Unlocked", loop_state, 2);
    check("R12 unlock alarm on enable", alarm_flags, 'b0001);
    tune_coarse = 10'h001;
    cmd(2);
    check("R11 load ignored when enabled", tune_code, 'h3FF0);
    cmd(3);
  endtask

  task automatic t_rails;
    send_n(-200, 4);
    check("R6 top rail saturates", tune_code, 'h3FFF);
    check("R6 top rail alarm", alarm_flags, 'b0100);
    send(0);
    cmd(0);
    tune_coarse = 10'h000;
    cmd(2);
    cmd(1);
    cmd(3);
    send_n(200, 4);
    check("R6 bottom rail saturates", tune_code, 0);
    check("R6 bottom rail alarm", alarm_flags, 'b0010);
    send(0);
  endtask

  task automatic t_misc;
    cfg_out_ctl = 1'b0;
    @(negedge clk);
    check("R13 always enabled without control", ref_out_en, 1);
    cfg_cycle_len = 16'd1;
    send(-20);
    check("R2 one-sample cycle", tune_code, 1);
    send(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sum_and_settle();
    t_coarse_slope();
    t_vote();
    t_holdover();
    t_alarm_clear();
    t_disable();
    t_rails();
    t_misc();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule